// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Resolver

This block decides which vector an interrupt acknowledge read returns, for a bank of 64 interrupt sources. Each source has a pending input and a configuration byte. The byte holds a mask bit, a 3-bit level and a 3-bit priority within that level. Software sets these bytes through a simple byte-wide register interface. The same interface also carries eight acknowledge reads. One is a software acknowledge, which looks at every level. The other seven are per-level acknowledges, one for each of levels 1 to 7.

A software acknowledge returns the vector of the best eligible source at any level. If no source is eligible, it returns zero, so an interrupt service routine can check cheaply for further work before it returns. A per-level acknowledge looks only at the requested level. If nothing there is eligible, it returns the spurious code 0x18. A per-level acknowledge also stores the level it served in a current-level register, which software can read back. An implicit acknowledge port is driven by the processor during exception entry. It reaches the same selection tree as the register reads, so both paths always give the same answer.

The read path is a two-state machine: `ST_IDLE` and `ST_REPLY`. There are three transitions:
- T_ACCEPT: `ST_IDLE` to `ST_REPLY`, on any strobe.
- T_BACK2BACK: `ST_REPLY` to `ST_REPLY`, on a new strobe.
- T_DONE: `ST_REPLY` to `ST_IDLE`, when there is no strobe.

Top module: `iack_resolver`

## Requirements
- R1: Address 0x00+i (i = 0..63) reads and writes the configuration byte of source i. Bit 7 is the mask (1 = masked). Bits 5:3 hold the level. Bits 2:0 hold the priority. Bit 6 always reads 0. After reset every byte reads 0x80.
- R2: A software acknowledge (read of 0x48, or implicit acknowledge with level 0) returns 64 + i for the eligible source i with the highest level. Ties are broken by the highest priority, then by the lowest index.
- R3: A software acknowledge with no eligible source returns 0x00.
- R4: A per-level acknowledge for level L (read of 0x48+L, or implicit acknowledge with level L, L = 1..7) considers only eligible sources whose level is L. It returns 64 + i for the one with the highest priority, and the lowest index wins a tie.
- R5: A per-level acknowledge with no eligible source at that level returns 0x18.
- R6: A source is eligible only when its pending input is high, its mask bit is 0 and its level is not 0.
- R7: Every per-level acknowledge loads L into the current-level register. Software reads this register at 0x40 in bits 2:0, with zeros above. A software acknowledge leaves it unchanged. It resets to 0.
- R8: Read data and `rd_valid` appear exactly one clock after the strobe and last one cycle. The result reflects the inputs and configuration at the strobe edge. `rd_data` is 0 whenever `rd_valid` is low.
- R9: When `iack_stb` and `rd_en` are high in the same cycle, the implicit acknowledge is served and the register read is dropped.
- R10: Reads of unmapped addresses return 0x00. Writes outside 0x00..0x3F change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend | input | 64 | Pending request of each source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| iack_stb | input | 1 | Implicit acknowledge strobe |
| iack_lvl | input | 3 | Level of the implicit acknowledge (0 = software) |
| rd_valid | output | 1 | Read data valid, one cycle after a strobe |
| rd_data | output | 8 | Read data or acknowledge vector |

## Verification
The bench sweeps every acknowledge address against many pending patterns and three configurations. One configuration puts many sources on a single level and priority. A resolver with the wrong tie direction would return a higher index there. One that ranked priority above level would pick a lower-level source on a software acknowledge. Empty levels, masked sources and level-0 sources are covered as well. A design that mixed up the two empty-result codes, or let a masked source through, would return a wrong vector. The bench also checks that the current-level register ignores software acknowledges and ignores writes. It checks that the result is held from the strobe edge even if `pend` drops right after. It checks that an implicit acknowledge wins over a register read issued in the same cycle.

// File: rtl/iack_pkg.sv
package iack_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] CURLVL_ADDR = 8'h40;
    localparam logic [ADDR_W-1:0] ACK_BASE    = 8'h48;
    localparam int MASK_BIT = 7;

    typedef enum logic [2:0] {
        REQ_NONE,
        REQ_CFG,
        REQ_CURLVL,
        REQ_ACK,
        REQ_UNMAPPED
    } req_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_REPLY
    } rd_state_e;
endpackage

// File: rtl/iack_cfg_bank.sv
module iack_cfg_bank #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3,
    parameter int PRI_W   = 3,
    parameter int IDX_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [7:0]                 wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [7:0]                 rd_cfg,
    output logic [NUM_SRC-1:0]         mask_o,
    output logic [NUM_SRC*LVL_W-1:0]   lvl_o,
    output logic [NUM_SRC*PRI_W-1:0]   pri_o
);
    import iack_pkg::*;

    localparam int LVL_LSB = PRI_W;
    localparam logic [7:0] SRC_LIMIT = 8'(NUM_SRC);

    logic               mask_q [NUM_SRC];
    logic [LVL_W-1:0]   lvl_q  [NUM_SRC];
    logic [PRI_W-1:0]   pri_q  [NUM_SRC];
    logic               wr_hit;
    logic               unused_wr_bits;

    assign wr_hit         = wr_en && (wr_addr < SRC_LIMIT);
    assign unused_wr_bits = ^wr_data[MASK_BIT-1:LVL_LSB+LVL_W];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[s] <= 1'b1;
                lvl_q[s]  <= '0;
                pri_q[s]  <= '0;
            end else if (wr_hit && (wr_addr[IDX_W-1:0] == IDX_W'(s))) begin
                mask_q[s] <= wr_data[MASK_BIT];
                lvl_q[s]  <= wr_data[LVL_LSB +: LVL_W];
                pri_q[s]  <= wr_data[0 +: PRI_W];
            end
        end
        assign mask_o[s]                 = mask_q[s];
        assign lvl_o[s*LVL_W +: LVL_W]   = lvl_q[s];
        assign pri_o[s*PRI_W +: PRI_W]   = pri_q[s];
    end

    always_comb begin
        rd_cfg                    = '0;
        rd_cfg[MASK_BIT]          = mask_q[rd_idx];
        rd_cfg[LVL_LSB +: LVL_W]  = lvl_q[rd_idx];
        rd_cfg[0 +: PRI_W]        = pri_q[rd_idx];
    end
endmodule

// File: rtl/iack_pick.sv
module iack_pick #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3,
    parameter int PRI_W   = 3,
    parameter int IDX_W   = 6
) (
    input  logic [NUM_SRC-1:0]         pend,
    input  logic [NUM_SRC-1:0]         mask,
    input  logic [NUM_SRC*LVL_W-1:0]   lvl,
    input  logic [NUM_SRC*PRI_W-1:0]   pri,
    input  logic [LVL_W-1:0]           sel_lvl,
    output logic                       found,
    output logic [IDX_W-1:0]           idx
);
    localparam int KEY_W  = LVL_W + PRI_W;
    localparam int PADDED = 1 << IDX_W;
    localparam int TOTAL  = 2 * PADDED - 1;
    localparam int LEAF0  = PADDED - 1;

    logic               nd_vld [TOTAL];
    logic [KEY_W-1:0]   nd_key [TOTAL];
    logic [IDX_W-1:0]   nd_idx [TOTAL];
    logic               any_level;

    assign any_level = (sel_lvl == '0);

    for (genvar i = 0; i < PADDED; i++) begin : g_leaf
        if (i < NUM_SRC) begin : g_real
            logic [LVL_W-1:0] src_lvl;
            logic             lvl_ok;
            assign src_lvl = lvl[i*LVL_W +: LVL_W];
            assign lvl_ok  = (src_lvl != '0) && (any_level || (src_lvl == sel_lvl));
            assign nd_vld[LEAF0+i] = pend[i] && !mask[i] && lvl_ok;
            assign nd_key[LEAF0+i] = {src_lvl, pri[i*PRI_W +: PRI_W]};
        end else begin : g_pad
            assign nd_vld[LEAF0+i] = 1'b0;
            assign nd_key[LEAF0+i] = '0;
        end
        assign nd_idx[LEAF0+i] = IDX_W'(i);
    end

    for (genvar n = 0; n < LEAF0; n++) begin : g_node
        logic take_right;
        assign take_right = nd_vld[2*n+2] &&
                            (!nd_vld[2*n+1] || (nd_key[2*n+2] > nd_key[2*n+1]));
        assign nd_vld[n]  = nd_vld[2*n+1] || nd_vld[2*n+2];
        assign nd_key[n]  = take_right ? nd_key[2*n+2] : nd_key[2*n+1];
        assign nd_idx[n]  = take_right ? nd_idx[2*n+2] : nd_idx[2*n+1];
    end

    assign found = nd_vld[0];
    assign idx   = nd_idx[0];
endmodule

// File: rtl/iack_rd_ctrl.sv
module iack_rd_ctrl #(
    parameter int NUM_SRC  = 64,
    parameter int LVL_W    = 3,
    parameter int IDX_W    = 6,
    parameter int VEC_BASE = 64,
    parameter int SPUR_VEC = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [7:0]         rd_addr,
    input  logic               iack_stb,
    input  logic [LVL_W-1:0]   iack_lvl,
    output logic [LVL_W-1:0]   sel_lvl,
    output logic [IDX_W-1:0]   cfg_idx,
    input  logic               pick_found,
    input  logic [IDX_W-1:0]   pick_idx,
    input  logic [7:0]         cfg_rdata,
    output logic               rd_valid,
    output logic [7:0]         rd_data
);
    import iack_pkg::*;

    localparam logic [7:0] SRC_LIMIT = 8'(NUM_SRC);

    req_kind_e          req_kind;
    logic [LVL_W-1:0]   req_lvl;
    logic               strobe;
    logic [7:0]         reply;
    rd_state_e          state_q, state_d;
    logic [LVL_W-1:0]   cur_lvl_q;

    // Request decode: the implicit acknowledge outranks a register read
    always_comb begin
        req_kind = REQ_NONE;
        req_lvl  = '0;
        if (iack_stb) begin
            req_kind = REQ_ACK;
            req_lvl  = iack_lvl;
        end else if (rd_en) begin
            if (rd_addr < SRC_LIMIT) begin
                req_kind = REQ_CFG;
            end else if (rd_addr == CURLVL_ADDR) begin
                req_kind = REQ_CURLVL;
            end else if (rd_addr[7:LVL_W] == ACK_BASE[7:LVL_W]) begin
                req_kind = REQ_ACK;
                req_lvl  = rd_addr[LVL_W-1:0];
            end else begin
                req_kind = REQ_UNMAPPED;
            end
        end
    end

    assign sel_lvl = req_lvl;
    assign cfg_idx = rd_addr[IDX_W-1:0];
    assign strobe  = (req_kind != REQ_NONE);

    always_comb begin
        unique case (req_kind)
            REQ_CFG:    reply = cfg_rdata;
            REQ_CURLVL: reply = 8'(cur_lvl_q);
            REQ_ACK: begin
                if (pick_found)            reply = 8'(VEC_BASE) + 8'(pick_idx);
                else if (req_lvl == '0)    reply = 8'h00;
                else                       reply = 8'(SPUR_VEC);
            end
            default:    reply = 8'h00;
        endcase
    end

    // Next state
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = strobe ? ST_REPLY : ST_IDLE;
            ST_REPLY: state_d = strobe ? ST_REPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data   <= '0;
            cur_lvl_q <= '0;
        end else begin
            rd_data <= (state_d == ST_REPLY) ? reply : 8'h00;
            if (req_kind == REQ_ACK && req_lvl != '0) begin
                cur_lvl_q <= req_lvl;
            end
        end
    end

    assign rd_valid = (state_q == ST_REPLY);
endmodule

// File: rtl/iack_resolver.sv
module iack_resolver #(
    parameter int NUM_SRC  = 64,
    parameter int LVL_W    = 3,
    parameter int PRI_W    = 3,
    parameter int VEC_BASE = 64,
    parameter int SPUR_VEC = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  pend,
    input  logic                wr_en,
    input  logic [7:0]          wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                rd_en,
    input  logic [7:0]          rd_addr,
    input  logic                iack_stb,
    input  logic [LVL_W-1:0]    iack_lvl,
    output logic                rd_valid,
    output logic [7:0]          rd_data
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0]        cfg_mask;
    logic [NUM_SRC*LVL_W-1:0]  cfg_lvl;
    logic [NUM_SRC*PRI_W-1:0]  cfg_pri;
    logic [IDX_W-1:0]          cfg_idx;
    logic [7:0]                cfg_rdata;
    logic [LVL_W-1:0]          sel_lvl;
    logic                      pick_found;
    logic [IDX_W-1:0]          pick_idx;

    iack_cfg_bank #(
        .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .PRI_W(PRI_W), .IDX_W(IDX_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_idx(cfg_idx), .rd_cfg(cfg_rdata),
        .mask_o(cfg_mask), .lvl_o(cfg_lvl), .pri_o(cfg_pri)
    );

    iack_pick #(
        .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .PRI_W(PRI_W), .IDX_W(IDX_W)
    ) u_pick (
        .pend(pend), .mask(cfg_mask), .lvl(cfg_lvl), .pri(cfg_pri),
        .sel_lvl(sel_lvl), .found(pick_found), .idx(pick_idx)
    );

    iack_rd_ctrl #(
        .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W),
        .VEC_BASE(VEC_BASE), .SPUR_VEC(SPUR_VEC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .iack_stb(iack_stb), .iack_lvl(iack_lvl),
        .sel_lvl(sel_lvl), .cfg_idx(cfg_idx),
        .pick_found(pick_found), .pick_idx(pick_idx),
        .cfg_rdata(cfg_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );
endmodule

// File: rtl/iack_resolver_chk.sv
module iack_resolver_chk #(
    parameter int LVL_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic [7:0]         rd_addr,
    input logic               iack_stb,
    input logic [LVL_W-1:0]   iack_lvl,
    input logic               rd_valid,
    input logic [7:0]         rd_data,
    input logic [LVL_W-1:0]   cur_lvl
);
    logic reg_lvl_ack;
    logic reg_sw_ack;
    logic reg_unmapped;

    assign reg_lvl_ack  = rd_en && !iack_stb && (rd_addr[7:3] == 5'b01001) && (rd_addr[2:0] != 3'd0);
    assign reg_sw_ack   = rd_en && !iack_stb && (rd_addr == 8'h48);
    assign reg_unmapped = rd_en && !iack_stb && (rd_addr >= 8'h41) && (rd_addr[7:3] != 5'b01001);

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || iack_stb) |=> rd_valid);                                             // R8
    AST_NO_VALID_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || iack_stb) |=> !rd_valid);                                           // R8
    AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == 8'h00));                                             // R8
    AST_SW_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((iack_stb && iack_lvl == '0) || reg_sw_ack) |=>
            (rd_data == 8'h00 || rd_data[7:6] == 2'b01));                              // R3
    AST_LVL_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((iack_stb && iack_lvl != '0) || reg_lvl_ack) |=>
            (rd_data == 8'h18 || rd_data[7:6] == 2'b01));                              // R5
    AST_CURLVL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_stb && iack_lvl != '0) |=> (cur_lvl == $past(iack_lvl)));               // R7
    AST_CURLVL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(iack_stb && iack_lvl != '0) && !reg_lvl_ack) |=> $stable(cur_lvl));        // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_unmapped |=> (rd_data == 8'h00));                                          // R10
endmodule

bind iack_resolver iack_resolver_chk #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .iack_stb(iack_stb), .iack_lvl(iack_lvl),
    .rd_valid(rd_valid), .rd_data(rd_data), .cur_lvl(u_ctrl.cur_lvl_q)
);

// File: tb/iack_resolver_test.sv
`timescale 1ns/1ps
module iack_resolver_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pend = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic        iack_stb = 1'b0;
    logic [2:0]  iack_lvl = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic       m_mask [64];
    logic [2:0] m_lvl  [64];
    logic [2:0] m_pri  [64];
    logic [2:0] m_cur  = '0;

    always #2.5 clk = ~clk;

    iack_resolver uut (
        .clk(clk), .rst_n(rst_n), .pend(pend),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .iack_stb(iack_stb), .iack_lvl(iack_lvl),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_ack(input int lv);
        int best;
        int bk;
        int k;
        best = -1;
        bk = -1;
        for (int i = 0; i < 64; i++) begin
            if (pend[i] && !m_mask[i] && m_lvl[i] != 0 && (lv == 0 || int'(m_lvl[i]) == lv)) begin
                k = int'(m_lvl[i]) * 8 + int'(m_pri[i]);
                if (k > bk) begin
                    bk = k;
                    best = i;
                end
            end
        end
        if (best >= 0) return 8'(64 + best);
        return (lv == 0) ? 8'h00 : 8'h18;
    endfunction

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic imp_ack(input logic [2:0] lv, output logic [7:0] d, output logic v);
        @(negedge clk);
        iack_stb = 1'b1;
        iack_lvl = lv;
        @(posedge clk);
        @(negedge clk);
        iack_stb = 1'b0;
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_src(input int i, input logic m, input logic [2:0] l, input logic [2:0] p);
        m_mask[i] = m;
        m_lvl[i] = l;
        m_pri[i] = p;
        cfg_write(8'(i), {m, i[0], l, p});
    endtask

    // Sweep every acknowledge level against one pending pattern
    task automatic sweep_levels(input bit use_port);
        logic [7:0] d;
        logic v;
        for (int lv = 0; lv < 8; lv++) begin
            if (use_port) imp_ack(3'(lv), d, v);
            else          bus_read(8'h48 + 8'(lv), d, v);
            check(lv == 0 ? "R2/R3/R6 sw ack" : "R4/R5/R6 level ack", d, model_ack(lv));
            check("R8 valid", {7'd0, v}, 8'h01);
            if (lv != 0) m_cur = 3'(lv);
            bus_read(8'h40, d, v);
            check("R7 current level", d, {5'd0, m_cur});
        end
    endtask

    function automatic logic [63:0] pattern(input int p);
        logic [63:0] x;
        x = 64'h9E37_79B9_7F4A_7C15 ^ (64'(p) * 64'h2545_F491_4F6C_DD1D);
        x = x ^ (x >> 29);
        x = x * 64'hBF58_476D_1CE4_E5B9;
        case (p % 4)
            0: return x & (x >> 7) & (x >> 13);
            1: return x & (x >> 5);
            2: return x;
            default: return 64'(1) << (p % 64);
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        logic v;
        for (int i = 0; i < 64; i++) begin
            m_mask[i] = 1'b1;
            m_lvl[i] = '0;
            m_pri[i] = '0;
        end
        repeat (3) @(negedge clk);
        check("R8 reset valid", {7'd0, rd_valid}, 8'h00);
        check("R8 reset data", rd_data, 8'h00);
        rst_n = 1'b1;

        // Reset configuration and empty acknowledges
        for (int i = 0; i < 64; i++) begin
            bus_read(8'(i), d, v);
            check("R1 reset cfg", d, 8'h80);
        end
        bus_read(8'h40, d, v);
        check("R7 reset current level", d, 8'h00);
        pend = '1;
        sweep_levels(1'b0);

        // Configuration A: spread levels and priorities, some masked
        for (int i = 0; i < 64; i++)
            set_src(i, (i % 7) == 3, 3'((i * 5 + 1) % 8), 3'((i * 3) % 8));
        for (int i = 0; i < 64; i++) begin
            bus_read(8'(i), d, v);
            check("R1 readback", d, {m_mask[i], 1'b0, m_lvl[i], m_pri[i]});
        end
        for (int p = 0; p < 24; p++) begin
            pend = pattern(p);
            sweep_levels(p[0]);
        end
        pend = '0;
        sweep_levels(1'b0);

        // Configuration B: many ties on one level and priority
        for (int i = 0; i < 64; i++)
            set_src(i, (i % 11) == 0, (i < 48) ? 3'd4 : 3'd0, (i % 16 == 9) ? 3'd3 : 3'd2);
        for (int p = 0; p < 12; p++) begin
            pend = pattern(p + 40);
            sweep_levels(p[0]);
        end

        // Configuration C: priorities descend with index, all levels used
        for (int i = 0; i < 64; i++)
            set_src(i, 1'b0, 3'(i % 8), 3'(7 - (i / 8)));
        for (int p = 0; p < 12; p++) begin
            pend = pattern(p + 80);
            sweep_levels(p[0]);
        end

        // R8: result fixed at the strobe edge even if pend drops after it
        pend = 64'(1) << 13;
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = 8'h48 + 8'(m_lvl[13]);
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        pend = '0;
        @(negedge clk);
        check("R8 sampled at strobe", rd_data, 8'd77);
        m_cur = m_lvl[13];
        @(negedge clk);
        check("R8 single-cycle valid", {7'd0, rd_valid}, 8'h00);
        check("R8 idle data zero", rd_data, 8'h00);

        // R9: implicit acknowledge wins over a same-cycle register read
        pend = '1;
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = 8'h05;
        iack_stb = 1'b1;
        iack_lvl = 3'd3;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        iack_stb = 1'b0;
        check("R9 precedence", rd_data, model_ack(3));
        m_cur = 3'd3;
        bus_read(8'h40, d, v);
        check("R9 current level after precedence", d, 8'h03);

        // R10: unmapped reads and ignored writes
        bus_read(8'h41, d, v);
        check("R10 unmapped 41", d, 8'h00);
        bus_read(8'h47, d, v);
        check("R10 unmapped 47", d, 8'h00);
        bus_read(8'h90, d, v);
        check("R10 unmapped 90", d, 8'h00);
        bus_read(8'hFF, d, v);
        check("R10 unmapped FF", d, 8'h00);
        cfg_write(8'h40, 8'h07);
        cfg_write(8'h4A, 8'hFF);
        cfg_write(8'hC5, 8'hBF);
        bus_read(8'h40, d, v);
        check("R10 current level unwritten", d, {5'd0, m_cur});
        bus_read(8'h05, d, v);
        check("R10 cfg untouched", d, {m_mask[5], 1'b0, m_lvl[5], m_pri[5]});
        bus_read(8'h48, d, v);
        check("R10 sw ack unchanged", d, model_ack(0));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule